// File: doc/BRIEF.md
# Prioritised Coprocessor Interrupt Controller

This block sits beside a small coprocessor core and decides, at every instruction boundary the core reports, whether the core takes an interrupt and which one. It holds three host-written registers (a control register with halt and request bits, a per-source enable register and an acknowledge register) together with a status register that shows one bit per source. Two event strobes feed it: one from a timer and one from a DMA engine. The core's interrupt-disable flag masks the maskable sources.

One non-maskable request is served first. After it come three maskable sources in fixed order: timer, DMA, then the external host request. Every source has an acknowledge bit, and while that bit is set the source cannot be taken again. The NMI sets its own acknowledge bit when it is taken. The timer and DMA sources are re-armed by their events. The NMI and external sources are re-armed when the host raises their request bit. If the core is parked in a wait-for-interrupt state when an interrupt is taken, the block releases it and tells it to step its program counter past the wait instruction. While either halt bit is set, the core is reported halted and nothing is taken.

Top module: `coirq_top`

## Requirements
- R1: After reset the status and acknowledge registers read 0x00, the control register holds halt bit 5 set (so `coreHalted` is 1), `waiting` is 0 and no take strobe is high.
- R2: While control bit 6 or control bit 5 is set, `coreHalted` is 1 and no interrupt is taken at any boundary.
- R3: The NMI is taken when control bit 4 is 1 and acknowledge bit 4 is 0. Taking it sets status bit 4 and acknowledge bit 4, so it does not fire again until a control write raises bit 4 from 0 to 1, which clears acknowledge bit 4.
- R4: At most one take strobe is high in any cycle, and the NMI wins over any maskable source at the same boundary.
- R5: Maskable sources are taken only when `intDisable` is 0 at the boundary.
- R6: The maskable order is timer, then DMA, then external. The timer qualifies when enable bit 6 is 1 and acknowledge bit 6 is 0. DMA qualifies when enable bit 5 is 1 and acknowledge bit 5 is 0. External qualifies when control bit 7 is 1 and acknowledge bit 7 is 0, and a control write raising bit 7 from 0 to 1 clears acknowledge bit 7. `irqSrc` reads 1 for timer, 2 for DMA and 3 for external, and taking a source sets its status bit (6, 5 or 7).
- R7: A `timerEvt` pulse always sets status bit 6. When enable bit 6 is 1, it also clears acknowledge bit 6.
- R8: A `dmaDone` pulse always sets status bit 5. When enable bit 5 is 1, it also clears acknowledge bit 5.
- R9: An acknowledge write sets every acknowledge bit written as 1 and clears the matching status bits. An event or take that sets a status bit in the same cycle wins over the clear.
- R10: A `waitEnter` pulse sets `waiting`. A take clears `waiting`, and if `waiting` was set, `pcAdvance` pulses in the same cycle as the take strobe.
- R11: Takes are decided only in cycles where `boundary` is 1. The strobes go high in the cycle after that boundary cycle and last one cycle per boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ctrlWe | input | 1 | Control register write enable |
| ctrlWdata | input | DATA_W | Control register write data |
| enWe | input | 1 | Enable register write enable |
| enWdata | input | DATA_W | Enable register write data |
| ackWe | input | 1 | Acknowledge register write enable (write 1s to set) |
| ackWdata | input | DATA_W | Acknowledge write data |
| timerEvt | input | 1 | Timer event strobe |
| dmaDone | input | 1 | DMA completion strobe |
| intDisable | input | 1 | Core interrupt-disable flag |
| boundary | input | 1 | Core is at an instruction boundary |
| waitEnter | input | 1 | Core enters wait-for-interrupt |
| takeNmi | output | 1 | Take-NMI pulse |
| takeIrq | output | 1 | Take-maskable-IRQ pulse |
| irqSrc | output | 2 | Source of the taken IRQ (1 timer, 2 DMA, 3 external) |
| pcAdvance | output | 1 | Step program counter once before vectoring |
| waiting | output | 1 | Core is in wait-for-interrupt |
| coreHalted | output | 1 | Core must not execute |
| statusRd | output | DATA_W | Status register |
| ackRd | output | DATA_W | Acknowledge register |

## Verification
The assertions hold on every cycle for the structural rules. Only one take strobe may be high at once. A halt, a set `intDisable` or a missing boundary suppresses takes in the next cycle. An NMI take always leaves its acknowledge bit set, a take always shows in the status bit of its source, a timer event always lands in status, and a `pcAdvance` pulse always comes with a take and a cleared wait flag. Only the directed scenarios can show that the right source is chosen from a given register state and that acknowledge writes and re-arming events move the priority chain from one source to the next. They also show that a request blocked by its acknowledge bit stays quiet across repeated boundaries, and that a disabled source's event marks status without re-arming it.

// File: rtl/coirq_pkg.sv
package coirq_pkg;
  localparam int SRC_W      = 2;
  localparam int HALT_A_BIT = 6;
  localparam int HALT_B_BIT = 5;
  localparam int NMI_BIT    = 4;
  localparam int TMR_BIT    = 6;
  localparam int DMA_BIT    = 5;
  localparam int EXT_BIT    = 7;

  localparam logic [SRC_W-1:0] SRC_NONE  = 2'd0;
  localparam logic [SRC_W-1:0] SRC_TIMER = 2'd1;
  localparam logic [SRC_W-1:0] SRC_DMA   = 2'd2;
  localparam logic [SRC_W-1:0] SRC_EXT   = 2'd3;

  // strobes from the decision logic to the register datapath
  typedef struct packed {
    logic nmi;
    logic timer;
    logic dma;
    logic ext;
    logic wake;
  } takeStbT;
endpackage

// File: rtl/coirq_ctrl.sv
module coirq_ctrl
  import coirq_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] ctrlQ,
  input  logic [DATA_W-1:0] enQ,
  input  logic [DATA_W-1:0] ackQ,
  input  logic              boundary,
  input  logic              intDisable,
  input  logic              waitingQ,
  output takeStbT           stb,
  output logic              coreHalted
);
  logic nmiQual, tmrQual, dmaQual, extQual;
  logic gate, maskGate;

  always_comb begin
    coreHalted = ctrlQ[HALT_A_BIT] | ctrlQ[HALT_B_BIT];
    nmiQual    = ctrlQ[NMI_BIT] & ~ackQ[NMI_BIT];
    tmrQual    = enQ[TMR_BIT]   & ~ackQ[TMR_BIT];
    dmaQual    = enQ[DMA_BIT]   & ~ackQ[DMA_BIT];
    extQual    = ctrlQ[EXT_BIT] & ~ackQ[EXT_BIT];
    gate       = boundary & ~coreHalted;
    maskGate   = gate & ~nmiQual & ~intDisable;

    stb.nmi    = gate & nmiQual;
    stb.timer  = maskGate & tmrQual;
    stb.dma    = maskGate & ~tmrQual & dmaQual;
    stb.ext    = maskGate & ~tmrQual & ~dmaQual & extQual;
    stb.wake   = waitingQ & (stb.nmi | stb.timer | stb.dma | stb.ext);
  end
endmodule

// File: rtl/coirq_dpath.sv
module coirq_dpath
  import coirq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] CTRL_RST = DATA_W'(1 << HALT_B_BIT)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctrlWe,
  input  logic [DATA_W-1:0] ctrlWdata,
  input  logic              enWe,
  input  logic [DATA_W-1:0] enWdata,
  input  logic              ackWe,
  input  logic [DATA_W-1:0] ackWdata,
  input  logic              timerEvt,
  input  logic              dmaDone,
  input  logic              waitEnter,
  input  takeStbT           stb,
  output logic [DATA_W-1:0] ctrlQ,
  output logic [DATA_W-1:0] enQ,
  output logic [DATA_W-1:0] ackQ,
  output logic [DATA_W-1:0] statusQ,
  output logic              waitingQ,
  output logic              takeNmiQ,
  output logic              takeIrqQ,
  output logic [SRC_W-1:0]  srcQ,
  output logic              pcAdvQ
);
  logic [DATA_W-1:0] ackSet, ackClr, stSet, stClr, ackNext, stNext;
  logic anyTake;
  logic [SRC_W-1:0] srcNext;

  always_comb begin
    anyTake = stb.nmi | stb.timer | stb.dma | stb.ext;

    ackSet = ackWe ? ackWdata : '0;
    ackSet[NMI_BIT] = ackSet[NMI_BIT] | stb.nmi;

    ackClr = '0;
    ackClr[TMR_BIT] = timerEvt & enQ[TMR_BIT];
    ackClr[DMA_BIT] = dmaDone & enQ[DMA_BIT];
    ackClr[NMI_BIT] = ctrlWe & ctrlWdata[NMI_BIT] & ~ctrlQ[NMI_BIT];
    ackClr[EXT_BIT] = ctrlWe & ctrlWdata[EXT_BIT] & ~ctrlQ[EXT_BIT];
    ackNext = (ackQ | ackSet) & ~ackClr;

    stClr = ackWe ? ackWdata : '0;
    stSet = '0;
    stSet[TMR_BIT] = timerEvt | stb.timer;
    stSet[DMA_BIT] = dmaDone | stb.dma;
    stSet[NMI_BIT] = stb.nmi;
    stSet[EXT_BIT] = stb.ext;
    stNext = (statusQ & ~stClr) | stSet;

    if (stb.timer)      srcNext = SRC_TIMER;
    else if (stb.dma)   srcNext = SRC_DMA;
    else if (stb.ext)   srcNext = SRC_EXT;
    else                srcNext = SRC_NONE;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlQ    <= CTRL_RST;
      enQ      <= '0;
      ackQ     <= '0;
      statusQ  <= '0;
      waitingQ <= 1'b0;
      takeNmiQ <= 1'b0;
      takeIrqQ <= 1'b0;
      srcQ     <= SRC_NONE;
      pcAdvQ   <= 1'b0;
    end else begin
      if (ctrlWe) ctrlQ <= ctrlWdata;
      if (enWe)   enQ   <= enWdata;
      ackQ     <= ackNext;
      statusQ  <= stNext;
      if (anyTake)        waitingQ <= 1'b0;
      else if (waitEnter) waitingQ <= 1'b1;
      takeNmiQ <= stb.nmi;
      takeIrqQ <= stb.timer | stb.dma | stb.ext;
      srcQ     <= srcNext;
      pcAdvQ   <= stb.wake;
    end
  end

  p_one_take_r4: assert property (@(posedge clk) disable iff (!rstN)
    !(takeNmiQ && takeIrqQ));
  p_nmi_ack_r3: assert property (@(posedge clk) disable iff (!rstN)
    takeNmiQ |-> ackQ[NMI_BIT]);
  p_wake_r10: assert property (@(posedge clk) disable iff (!rstN)
    pcAdvQ |-> ((takeNmiQ || takeIrqQ) && !waitingQ));
  p_take_status_r6: assert property (@(posedge clk) disable iff (!rstN)
    takeIrqQ |-> ((srcQ == SRC_TIMER && statusQ[TMR_BIT]) ||
                  (srcQ == SRC_DMA   && statusQ[DMA_BIT]) ||
                  (srcQ == SRC_EXT   && statusQ[EXT_BIT])));
  p_timer_status_r7: assert property (@(posedge clk) disable iff (!rstN)
    timerEvt |=> statusQ[TMR_BIT]);
endmodule

// File: rtl/coirq_top.sv
module coirq_top
  import coirq_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctrlWe,
  input  logic [DATA_W-1:0] ctrlWdata,
  input  logic              enWe,
  input  logic [DATA_W-1:0] enWdata,
  input  logic              ackWe,
  input  logic [DATA_W-1:0] ackWdata,
  input  logic              timerEvt,
  input  logic              dmaDone,
  input  logic              intDisable,
  input  logic              boundary,
  input  logic              waitEnter,
  output logic              takeNmi,
  output logic              takeIrq,
  output logic [1:0]        irqSrc,
  output logic              pcAdvance,
  output logic              waiting,
  output logic              coreHalted,
  output logic [DATA_W-1:0] statusRd,
  output logic [DATA_W-1:0] ackRd
);
  logic [DATA_W-1:0] ctrlQ, enQ;
  takeStbT stb;

  coirq_ctrl #(.DATA_W(DATA_W)) ctrl_i (
    .ctrlQ(ctrlQ), .enQ(enQ), .ackQ(ackRd), .boundary(boundary),
    .intDisable(intDisable), .waitingQ(waiting), .stb(stb),
    .coreHalted(coreHalted)
  );

  coirq_dpath #(.DATA_W(DATA_W)) dpath_i (
    .clk(clk), .rstN(rstN), .ctrlWe(ctrlWe), .ctrlWdata(ctrlWdata),
    .enWe(enWe), .enWdata(enWdata), .ackWe(ackWe), .ackWdata(ackWdata),
    .timerEvt(timerEvt), .dmaDone(dmaDone), .waitEnter(waitEnter),
    .stb(stb), .ctrlQ(ctrlQ), .enQ(enQ), .ackQ(ackRd), .statusQ(statusRd),
    .waitingQ(waiting), .takeNmiQ(takeNmi), .takeIrqQ(takeIrq),
    .srcQ(irqSrc), .pcAdvQ(pcAdvance)
  );

  p_halt_r2: assert property (@(posedge clk) disable iff (!rstN)
    coreHalted |=> !(takeNmi || takeIrq));
  p_mask_r5: assert property (@(posedge clk) disable iff (!rstN)
    intDisable |=> !takeIrq);
  p_boundary_r11: assert property (@(posedge clk) disable iff (!rstN)
    !boundary |=> !(takeNmi || takeIrq));
endmodule

// File: tb/coirq_top_tb_top.sv
module coirq_top_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ctrlWe = 0, enWe = 0, ackWe = 0;
  logic [7:0] ctrlWdata = '0, enWdata = '0, ackWdata = '0;
  logic timerEvt = 0, dmaDone = 0, intDisable = 1, boundary = 0, waitEnter = 0;
  logic takeNmi, takeIrq, pcAdvance, waiting, coreHalted;
  logic [1:0] irqSrc;
  logic [7:0] statusRd, ackRd;
  int vectors = 0, miscompares = 0;

  always #5 clk = ~clk;

  coirq_top dut_i (
    .clk(clk), .rstN(rstN), .ctrlWe(ctrlWe), .ctrlWdata(ctrlWdata),
    .enWe(enWe), .enWdata(enWdata), .ackWe(ackWe), .ackWdata(ackWdata),
    .timerEvt(timerEvt), .dmaDone(dmaDone), .intDisable(intDisable),
    .boundary(boundary), .waitEnter(waitEnter), .takeNmi(takeNmi),
    .takeIrq(takeIrq), .irqSrc(irqSrc), .pcAdvance(pcAdvance),
    .waiting(waiting), .coreHalted(coreHalted), .statusRd(statusRd),
    .ackRd(ackRd)
  );

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wrCtrl(input logic [7:0] d);
    ctrlWe = 1; ctrlWdata = d; tick(); ctrlWe = 0;
  endtask
  task automatic wrEn(input logic [7:0] d);
    enWe = 1; enWdata = d; tick(); enWe = 0;
  endtask
  task automatic wrAck(input logic [7:0] d);
    ackWe = 1; ackWdata = d; tick(); ackWe = 0;
  endtask
  task automatic atBoundary();
    boundary = 1; tick(); boundary = 0;
  endtask

  task automatic t_reset();
    chk("R1 status", statusRd, 8'h00);
    chk("R1 ack", ackRd, 8'h00);
    chk("R1 halted", coreHalted, 1);
    chk("R1 waiting", waiting, 0);
    chk("R1 takes", {takeNmi, takeIrq}, 0);
  endtask

  task automatic t_halt();
    wrCtrl(8'h30); atBoundary();
    chk("R2 halt bit5 blocks NMI", takeNmi, 0);
    chk("R2 halted bit5", coreHalted, 1);
    wrCtrl(8'h50); atBoundary();
    chk("R2 halt bit6 blocks NMI", takeNmi, 0);
    chk("R2 halted bit6", coreHalted, 1);
  endtask

  task automatic t_nmi();
    wrCtrl(8'h10);
    chk("R2 running", coreHalted, 0);
    atBoundary();
    chk("R3 NMI taken", takeNmi, 1);
    chk("R3 no IRQ", takeIrq, 0);
    chk("R3 status4", statusRd, 8'h10);
    chk("R3 ack4", ackRd, 8'h10);
    atBoundary();
    chk("R3 no re-fire", takeNmi, 0);
  endtask

  task automatic t_boundaryOnly();
    wrCtrl(8'h00); wrCtrl(8'h10);
    chk("R3 rearm clears ack4", ackRd, 8'h00);
    for (int i = 0; i < 3; i++) begin
      tick();
      chk("R11 no take without boundary", takeNmi, 0);
    end
    atBoundary();
    chk("R11 take after boundary", takeNmi, 1);
    tick();
    chk("R11 single-cycle pulse", takeNmi, 0);
  endtask

  task automatic t_priority();
    wrCtrl(8'h80); wrEn(8'h60);
    intDisable = 1; atBoundary();
    chk("R5 masked", takeIrq, 0);
    intDisable = 0; atBoundary();
    chk("R6 timer taken", {takeIrq, irqSrc}, 3'b101);
    chk("R6 status timer", statusRd, 8'h50);
    atBoundary();
    chk("R6 timer again", {takeIrq, irqSrc}, 3'b101);
    wrAck(8'h40);
    chk("R9 ack set, status cleared", {ackRd, statusRd}, 16'h5010);
    atBoundary();
    chk("R6 dma taken", {takeIrq, irqSrc}, 3'b110);
    chk("R6 status dma", statusRd, 8'h30);
    wrAck(8'h20); atBoundary();
    chk("R6 ext taken", {takeIrq, irqSrc}, 3'b111);
    chk("R6 status ext", statusRd, 8'h90);
    wrAck(8'h80); atBoundary();
    chk("R6 nothing left", {takeNmi, takeIrq}, 0);
  endtask

  task automatic t_nmiWins();
    wrCtrl(8'h90);
    chk("R3 rearm ack", ackRd, 8'hE0);
    timerEvt = 1; tick(); timerEvt = 0;
    atBoundary();
    chk("R4 NMI wins", {takeNmi, takeIrq}, 2'b10);
    atBoundary();
    chk("R4 timer next", {takeIrq, irqSrc}, 3'b101);
  endtask

  task automatic t_timerEvt();
    wrEn(8'h20); wrAck(8'h40);
    chk("R9 status6 cleared", statusRd, 8'h10);
    timerEvt = 1; tick(); timerEvt = 0;
    chk("R7 status6 set", statusRd, 8'h50);
    chk("R7 ack kept when disabled", ackRd, 8'hF0);
    wrEn(8'h60);
    timerEvt = 1; tick(); timerEvt = 0;
    chk("R7 ack6 cleared when enabled", ackRd, 8'hB0);
  endtask

  task automatic t_dma();
    wrAck(8'h20);
    dmaDone = 1; tick(); dmaDone = 0;
    chk("R8 status5 set", statusRd, 8'h70);
    chk("R8 ack5 cleared", ackRd, 8'h90);
    wrEn(8'h40); wrAck(8'h20);
    chk("R9 status5 cleared", statusRd, 8'h50);
    dmaDone = 1; tick(); dmaDone = 0;
    chk("R8 status5 when disabled", statusRd, 8'h70);
    chk("R8 ack kept when disabled", ackRd, 8'hB0);
  endtask

  task automatic t_wait();
    intDisable = 1;
    wrCtrl(8'h80); wrCtrl(8'h90);
    waitEnter = 1; tick(); waitEnter = 0;
    chk("R10 waiting set", waiting, 1);
    atBoundary();
    chk("R10 take+advance", {takeNmi, pcAdvance}, 2'b11);
    chk("R10 waiting cleared", waiting, 0);
    tick();
    chk("R10 advance single", pcAdvance, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    tick();
    t_reset();
    t_halt();
    t_nmi();
    t_boundaryOnly();
    t_priority();
    t_nmiWins();
    t_timerEvt();
    t_dma();
    t_wait();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule